// File: doc/BRIEF.md
# Slice Replay and Validation Unit

This unit repairs program state after a value prediction turns out wrong, without throwing away all the work done since the prediction. A slice of instructions that depend on the predicted seed value has already been collected, together with the live-in register values and the addresses and branch outcomes seen in the first run. When the seed resolves and the corrected value differs from the prediction, the unit reads the slice back one entry per cycle, strictly in program order. It recomputes every result against a private copy of the registers and checks at each step that the replay is equivalent to the first run in every respect that matters to code outside the slice.

If every check holds, the unit streams the written registers back to the main register file and then streams the coalesced stores out to be merged into memory. During the replay it also announces each address stored to for the first time, so that the old contents can be logged for undo. If any check fails, the replay stops at once and the unit asks for a conventional squash of the task. When the prediction was right, the slice is discarded at once.

Top module: `slice_replay_unit`

## Requirements
- R1: When resolve_valid arrives while idle and correct_value equals pred_value, done and success pulse on the next cycle, no slice entry is read and nothing is written back or merged.
- R2: On a misprediction the unit reads slice entries one per cycle with slice_rd_idx going 0, 1, 2, ... up to slice_len-1, and reads none when slice_len is 0.
- R3: The replay register copy starts from livein_regs (register i in bits i*DW upward), with the seed register replaced by correct_value. Op code 0 writes src1+src2 to dst. Op code 1 loads into dst from address src1+imm. Op code 2 stores src2 to address src1+imm. Op code 3 is a branch, taken when src1 equals src2.
- R4: A branch whose replayed direction differs from sl_orig_taken fails the replay.
- R5: A load whose replayed address differs from sl_orig_addr fails the replay.
- R6: A store whose replayed address differs from sl_orig_addr fails the replay only if rdset_hit is high for that address. Otherwise the replay continues.
- R7: undo_valid pulses with the address for the first store to each address in a replay only. A later store to the same address updates the buffered data and does not pulse.
- R8: On success, wb_valid presents the seed register and every register written by the replay, in ascending index order. After that, merge_valid presents each buffered store with its last data, in the order its address first appeared.
- R9: On failure, squash_req is high for one cycle, followed by done with fail, and no write-back or merge is presented.
- R10: done is a one-cycle pulse carrying exactly one of success or fail, and neither appears without done.
- R11: A store to a new address when SDEPTH distinct addresses are already buffered fails the replay.
- R12: After a failing entry, no further slice entries are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resolve_valid | input | 1 | Seed value has resolved |
| pred_value | input | DW | Value that was predicted for the seed |
| correct_value | input | DW | Resolved seed value |
| seed_reg | input | log2(NREG) | Register that holds the seed |
| slice_len | input | log2(MAXLEN)+1 | Number of buffered slice entries |
| livein_regs | input | NREG*DW | Saved live-in register values |
| slice_rd_en | output | 1 | Slice entry read strobe |
| slice_rd_idx | output | log2(MAXLEN) | Slice entry index |
| sl_op | input | 2 | Entry op code |
| sl_dst | input | log2(NREG) | Entry destination register |
| sl_src1 | input | log2(NREG) | Entry first source / base register |
| sl_src2 | input | log2(NREG) | Entry second source / store data register |
| sl_imm | input | DW | Entry address offset |
| sl_orig_addr | input | DW | Address used by the entry in the first run |
| sl_orig_taken | input | 1 | Branch direction in the first run |
| mem_req | output | 1 | Load read request |
| mem_addr | output | DW | Load address |
| mem_rdata | input | DW | Load data, same cycle |
| rdset_addr | output | DW | Address queried against the first-run read set |
| rdset_hit | input | 1 | Queried address was read outside the slice in the first run |
| undo_valid | output | 1 | First store to an address |
| undo_addr | output | DW | Address to log for undo |
| wb_valid | output | 1 | Register write-back valid |
| wb_idx | output | log2(NREG) | Write-back register index |
| wb_data | output | DW | Write-back value |
| merge_valid | output | 1 | Store merge valid |
| merge_addr | output | DW | Store merge address |
| merge_data | output | DW | Store merge data |
| squash_req | output | 1 | Request for conventional squash |
| done | output | 1 | Outcome pulse |
| success | output | 1 | Replay result may stand |
| fail | output | 1 | Replay rejected |

## Verification
A wrong replay register value reaches the ports within one entry, either as a changed load or store address on mem_addr and rdset_addr or, at the end, as a wrong wb_data. A corrupted program counter shows on slice_rd_idx in the very next cycle. A lost or misplaced violation flag shows as the wrong outcome bit on done and as write-backs or merges that should not appear after a failure. Faults in the store buffer show as an extra or missing undo_valid pulse during the replay, or as a wrong merge stream roughly NREG cycles after the replay ends.

// File: rtl/slice_replay_pkg.sv
package slice_replay_pkg;

  typedef enum logic [1:0] {
    OP_ADD    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_BRANCH = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REPLAY,
    ST_CHECK,
    ST_MERGE,
    ST_SQUASH,
    ST_DONE
  } state_e;

endpackage

// File: rtl/replay_regfile.sv
module replay_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_en,
  input  logic [NREG*DW-1:0] init_vec,
  input  logic [RW-1:0]      seed_idx,
  input  logic [DW-1:0]      seed_val,
  input  logic               wr_en,
  input  logic [RW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [RW-1:0]      rd_a_idx,
  output logic [DW-1:0]      rd_a,
  input  logic [RW-1:0]      rd_b_idx,
  output logic [DW-1:0]      rd_b,
  input  logic [RW-1:0]      rd_m_idx,
  output logic [DW-1:0]      rd_m,
  output logic               dirty_m
);

  logic [DW-1:0]   regs_q [NREG];
  logic [DW-1:0]   regs_d [NREG];
  logic [NREG-1:0] dirty_q, dirty_d;

  always_comb begin
    regs_d  = regs_q;
    dirty_d = dirty_q;
    if (init_en) begin
      for (int i = 0; i < NREG; i++) regs_d[i] = init_vec[i*DW +: DW];
      regs_d[seed_idx]  = seed_val;
      dirty_d           = '0;
      dirty_d[seed_idx] = 1'b1;
    end else if (wr_en) begin
      regs_d[wr_idx]  = wr_data;
      dirty_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      dirty_q <= '0;
    end else if (init_en || wr_en) begin
      regs_q  <= regs_d;
      dirty_q <= dirty_d;
    end
  end

  assign rd_a    = regs_q[rd_a_idx];
  assign rd_b    = regs_q[rd_b_idx];
  assign rd_m    = regs_q[rd_m_idx];
  assign dirty_m = dirty_q[rd_m_idx];

  // A register write lands in the register copy on the next edge
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init_en) |=> regs_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/replay_store_buf.sv
module replay_store_buf #(
  parameter int SDEPTH = 4,
  parameter int DW     = 16,
  localparam int SW    = (SDEPTH > 1) ? $clog2(SDEPTH) : 1,
  localparam int CW    = $clog2(SDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hit,
  output logic          full,
  input  logic [SW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [SDEPTH-1:0] valid_q, valid_d;
  logic [DW-1:0]     addr_q [SDEPTH];
  logic [DW-1:0]     addr_d [SDEPTH];
  logic [DW-1:0]     data_q [SDEPTH];
  logic [DW-1:0]     data_d [SDEPTH];
  logic [CW-1:0]     count_q, count_d;
  logic [SDEPTH-1:0] match;

  for (genvar g = 0; g < SDEPTH; g++) begin : g_match
    assign match[g] = valid_q[g] && (addr_q[g] == wr_addr);
  end

  assign hit  = |match;
  assign full = (count_q == CW'(SDEPTH));

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    data_d  = data_q;
    count_d = count_q;
    if (clr) begin
      valid_d = '0;
      count_d = '0;
    end else if (wr_en) begin
      if (hit) begin
        for (int i = 0; i < SDEPTH; i++)
          if (match[i]) data_d[i] = wr_data;
      end else if (!full) begin
        valid_d[SW'(count_q)] = 1'b1;
        addr_d[SW'(count_q)]  = wr_addr;
        data_d[SW'(count_q)]  = wr_data;
        count_d               = count_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      count_q <= '0;
      for (int i = 0; i < SDEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else if (clr || wr_en) begin
      valid_q <= valid_d;
      count_q <= count_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_addr  = addr_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  // Coalescing keeps each address in at most one entry
  p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // Occupancy never passes the buffer depth
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(SDEPTH));

endmodule

// File: rtl/replay_exec.sv
module replay_exec
  import slice_replay_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] orig_addr,
  input  logic          orig_taken,
  input  logic [DW-1:0] mem_rdata,
  input  logic          rdset_hit,
  input  logic          sb_hit,
  input  logic          sb_full,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] result,
  output logic          wr_reg,
  output logic          st_accept,
  output logic          ld_req,
  output logic          violation
);

  logic moved;

  assign addr  = opa + imm;
  assign moved = (addr != orig_addr);

  always_comb begin
    result    = opa + opb;
    wr_reg    = 1'b0;
    st_accept = 1'b0;
    ld_req    = 1'b0;
    violation = 1'b0;
    unique case (op)
      OP_ADD: wr_reg = 1'b1;
      OP_LOAD: begin
        ld_req = 1'b1;
        result = mem_rdata;
        if (moved) violation = 1'b1;
        else       wr_reg    = 1'b1;
      end
      OP_STORE: begin
        if ((moved && rdset_hit) || (!sb_hit && sb_full)) violation = 1'b1;
        else                                              st_accept = 1'b1;
      end
      OP_BRANCH: begin
        if ((opa == opb) != orig_taken) violation = 1'b1;
      end
      default: violation = 1'b1;
    endcase
  end

endmodule

// File: rtl/slice_replay_unit.sv
module slice_replay_unit
  import slice_replay_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int MAXLEN = 32,
  parameter int SDEPTH = 4,
  localparam int RW    = $clog2(NREG),
  localparam int LW    = $clog2(MAXLEN),
  localparam int LENW  = LW + 1,
  localparam int SW    = (SDEPTH > 1) ? $clog2(SDEPTH) : 1,
  localparam int MW    = $clog2(NREG + SDEPTH),
  localparam int MLAST = NREG + SDEPTH - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resolve_valid,
  input  logic [DW-1:0]      pred_value,
  input  logic [DW-1:0]      correct_value,
  input  logic [RW-1:0]      seed_reg,
  input  logic [LENW-1:0]    slice_len,
  input  logic [NREG*DW-1:0] livein_regs,
  output logic               slice_rd_en,
  output logic [LW-1:0]      slice_rd_idx,
  input  logic [1:0]         sl_op,
  input  logic [RW-1:0]      sl_dst,
  input  logic [RW-1:0]      sl_src1,
  input  logic [RW-1:0]      sl_src2,
  input  logic [DW-1:0]      sl_imm,
  input  logic [DW-1:0]      sl_orig_addr,
  input  logic               sl_orig_taken,
  output logic               mem_req,
  output logic [DW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic [DW-1:0]      rdset_addr,
  input  logic               rdset_hit,
  output logic               undo_valid,
  output logic [DW-1:0]      undo_addr,
  output logic               wb_valid,
  output logic [RW-1:0]      wb_idx,
  output logic [DW-1:0]      wb_data,
  output logic               merge_valid,
  output logic [DW-1:0]      merge_addr,
  output logic [DW-1:0]      merge_data,
  output logic               squash_req,
  output logic               done,
  output logic               success,
  output logic               fail
);

  state_e          state_q, state_d;
  logic [LW-1:0]   pc_q, pc_d;
  logic [LENW-1:0] len_q, len_d;
  logic            ok_q, ok_d;
  logic [MW-1:0]   mcnt_q, mcnt_d;

  logic in_replay, in_merge, start_replay, mispredict;
  logic [DW-1:0] opa, opb, ex_addr, ex_result;
  logic ex_wr, ex_st, ex_ld, ex_viol, viol;
  logic sb_hit, sb_full, sb_rd_valid;
  logic [DW-1:0] sb_rd_addr, sb_rd_data, rf_m;
  logic rf_dirty_m, merge_regs;

  assign in_replay  = (state_q == ST_REPLAY);
  assign in_merge   = (state_q == ST_MERGE);
  assign mispredict = (pred_value != correct_value);
  assign start_replay = (state_q == ST_IDLE) && resolve_valid && mispredict;
  assign viol       = in_replay && ex_viol;
  assign merge_regs = (mcnt_q < MW'(NREG));

  replay_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_en  (start_replay),
    .init_vec (livein_regs),
    .seed_idx (seed_reg),
    .seed_val (correct_value),
    .wr_en    (in_replay && ex_wr),
    .wr_idx   (sl_dst),
    .wr_data  (ex_result),
    .rd_a_idx (sl_src1),
    .rd_a     (opa),
    .rd_b_idx (sl_src2),
    .rd_b     (opb),
    .rd_m_idx (RW'(mcnt_q)),
    .rd_m     (rf_m),
    .dirty_m  (rf_dirty_m)
  );

  replay_exec #(.DW(DW)) u_exec (
    .op         (op_e'(sl_op)),
    .opa        (opa),
    .opb        (opb),
    .imm        (sl_imm),
    .orig_addr  (sl_orig_addr),
    .orig_taken (sl_orig_taken),
    .mem_rdata  (mem_rdata),
    .rdset_hit  (rdset_hit),
    .sb_hit     (sb_hit),
    .sb_full    (sb_full),
    .addr       (ex_addr),
    .result     (ex_result),
    .wr_reg     (ex_wr),
    .st_accept  (ex_st),
    .ld_req     (ex_ld),
    .violation  (ex_viol)
  );

  replay_store_buf #(.SDEPTH(SDEPTH), .DW(DW)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_replay),
    .wr_en    (in_replay && ex_st),
    .wr_addr  (ex_addr),
    .wr_data  (opb),
    .hit      (sb_hit),
    .full     (sb_full),
    .rd_idx   (SW'(mcnt_q - MW'(NREG))),
    .rd_valid (sb_rd_valid),
    .rd_addr  (sb_rd_addr),
    .rd_data  (sb_rd_data)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    len_d   = len_q;
    ok_d    = ok_q;
    mcnt_d  = mcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (resolve_valid) begin
          ok_d = 1'b1;
          if (!mispredict) begin
            state_d = ST_DONE;
          end else begin
            pc_d    = '0;
            len_d   = slice_len;
            state_d = (slice_len == '0) ? ST_CHECK : ST_REPLAY;
          end
        end
      end
      ST_REPLAY: begin
        if (viol) begin
          ok_d    = 1'b0;
          state_d = ST_CHECK;
        end else begin
          pc_d = pc_q + LW'(1);
          if (({1'b0, pc_q} + LENW'(1)) == len_q) state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        mcnt_d  = '0;
        state_d = ok_q ? ST_MERGE : ST_SQUASH;
      end
      ST_MERGE: begin
        mcnt_d = mcnt_q + MW'(1);
        if (mcnt_q == MW'(MLAST)) state_d = ST_DONE;
      end
      ST_SQUASH: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      len_q   <= '0;
      ok_q    <= 1'b0;
      mcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      len_q   <= len_d;
      ok_q    <= ok_d;
      mcnt_q  <= mcnt_d;
    end
  end

  assign slice_rd_en  = in_replay;
  assign slice_rd_idx = pc_q;
  assign mem_req      = in_replay && ex_ld;
  assign mem_addr     = ex_addr;
  assign rdset_addr   = ex_addr;
  assign undo_valid   = in_replay && ex_st && !sb_hit;
  assign undo_addr    = ex_addr;
  assign wb_valid     = in_merge && merge_regs && rf_dirty_m;
  assign wb_idx       = RW'(mcnt_q);
  assign wb_data      = rf_m;
  assign merge_valid  = in_merge && !merge_regs && sb_rd_valid;
  assign merge_addr   = sb_rd_addr;
  assign merge_data   = sb_rd_data;
  assign squash_req   = (state_q == ST_SQUASH);
  assign done         = (state_q == ST_DONE);
  assign success      = done && ok_q;
  assign fail         = done && !ok_q;

  // Outcome carries exactly one verdict
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (success ^ fail));
  p_verdict_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (success || fail) |-> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Entries are read back to back in program order
  p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_rd_en && $past(slice_rd_en)) |-> slice_rd_idx == $past(slice_rd_idx) + LW'(1));

  // A correct prediction completes at once
  p_discard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && resolve_valid && !mispredict) |=> (success && !slice_rd_en));

  // A violation stops reading and suppresses any commit
  p_stop_on_fail_r12: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !slice_rd_en && !wb_valid && !merge_valid);

  // A squash request is followed by the fail verdict
  p_squash_then_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req |=> (done && fail));

endmodule

// File: tb/slice_replay_unit_test.sv
module slice_replay_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, NREG = 8, MAXLEN = 32, SDEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              resolve_valid = 1'b0;
  logic [DW-1:0]     pred_value = '0, correct_value = '0;
  logic [2:0]        seed_reg = 3'd1;
  logic [5:0]        slice_len = '0;
  logic [NREG*DW-1:0] livein_regs;
  logic              slice_rd_en;
  logic [4:0]        slice_rd_idx;
  logic [1:0]        sl_op;
  logic [2:0]        sl_dst, sl_src1, sl_src2;
  logic [DW-1:0]     sl_imm, sl_orig_addr;
  logic              sl_orig_taken;
  logic              mem_req;
  logic [DW-1:0]     mem_addr, mem_rdata, rdset_addr;
  logic              rdset_hit;
  logic              undo_valid;
  logic [DW-1:0]     undo_addr;
  logic              wb_valid;
  logic [2:0]        wb_idx;
  logic [DW-1:0]     wb_data;
  logic              merge_valid;
  logic [DW-1:0]     merge_addr, merge_data;
  logic              squash_req, done, success, fail;

  // Bench-side slice storage and memory model
  logic [1:0]    t_op    [MAXLEN];
  logic [2:0]    t_dst   [MAXLEN];
  logic [2:0]    t_s1    [MAXLEN];
  logic [2:0]    t_s2    [MAXLEN];
  logic [DW-1:0] t_imm   [MAXLEN];
  logic [DW-1:0] t_oaddr [MAXLEN];
  logic          t_otk   [MAXLEN];
  logic [DW-1:0] hit_addr = 16'hFFFF;

  assign sl_op         = t_op[slice_rd_idx];
  assign sl_dst        = t_dst[slice_rd_idx];
  assign sl_src1       = t_s1[slice_rd_idx];
  assign sl_src2       = t_s2[slice_rd_idx];
  assign sl_imm        = t_imm[slice_rd_idx];
  assign sl_orig_addr  = t_oaddr[slice_rd_idx];
  assign sl_orig_taken = t_otk[slice_rd_idx];
  assign mem_rdata     = mem_addr ^ 16'h5A5A;
  assign rdset_hit     = (rdset_addr == hit_addr);

  for (genvar g = 0; g < NREG; g++) begin : g_live
    assign livein_regs[g*DW +: DW] = DW'(g * 16'h0100);
  end

  slice_replay_unit #(.DW(DW), .NREG(NREG), .MAXLEN(MAXLEN), .SDEPTH(SDEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .resolve_valid(resolve_valid),
    .pred_value(pred_value), .correct_value(correct_value), .seed_reg(seed_reg),
    .slice_len(slice_len), .livein_regs(livein_regs),
    .slice_rd_en(slice_rd_en), .slice_rd_idx(slice_rd_idx),
    .sl_op(sl_op), .sl_dst(sl_dst), .sl_src1(sl_src1), .sl_src2(sl_src2),
    .sl_imm(sl_imm), .sl_orig_addr(sl_orig_addr), .sl_orig_taken(sl_orig_taken),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rdset_addr(rdset_addr), .rdset_hit(rdset_hit),
    .undo_valid(undo_valid), .undo_addr(undo_addr),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .merge_valid(merge_valid), .merge_addr(merge_addr), .merge_data(merge_data),
    .squash_req(squash_req), .done(done), .success(success), .fail(fail)
  );

  int checks = 0, errors = 0;

  // Event logs gathered at the falling edge
  int rd_cnt, wb_cnt, mg_cnt, undo_cnt, sq_cnt, done_cnt, bad_order, both_cnt;
  logic last_succ, last_fail;
  logic [2:0]    wb_i [16];
  logic [DW-1:0] wb_d [16];
  logic [DW-1:0] mg_a [16];
  logic [DW-1:0] mg_d [16];
  logic [DW-1:0] un_a [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (slice_rd_en) begin
        if (int'(slice_rd_idx) != rd_cnt) bad_order++;
        rd_cnt++;
      end
      if (wb_valid && wb_cnt < 16) begin wb_i[wb_cnt] = wb_idx; wb_d[wb_cnt] = wb_data; wb_cnt++; end
      if (merge_valid && mg_cnt < 16) begin mg_a[mg_cnt] = merge_addr; mg_d[mg_cnt] = merge_data; mg_cnt++; end
      if (undo_valid && undo_cnt < 16) begin un_a[undo_cnt] = undo_addr; undo_cnt++; end
      if (squash_req) sq_cnt++;
      if ((success || fail) && !done) both_cnt++;
      if (done) begin
        done_cnt++;
        last_succ = success;
        last_fail = fail;
        if (success == fail) both_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_slice();
    for (int i = 0; i < MAXLEN; i++) begin
      t_op[i] = 2'd0; t_dst[i] = 3'd0; t_s1[i] = 3'd0; t_s2[i] = 3'd0;
      t_imm[i] = '0; t_oaddr[i] = '0; t_otk[i] = 1'b0;
    end
  endtask

  task automatic set_ent(input int i, input logic [1:0] op, input logic [2:0] d,
                         input logic [2:0] s1, input logic [2:0] s2,
                         input logic [DW-1:0] imm, input logic [DW-1:0] oa, input logic tk);
    t_op[i] = op; t_dst[i] = d; t_s1[i] = s1; t_s2[i] = s2;
    t_imm[i] = imm; t_oaddr[i] = oa; t_otk[i] = tk;
  endtask

  // Pulses resolve and waits for the outcome, then a few quiet cycles
  task automatic run(input logic [DW-1:0] pv, input logic [DW-1:0] cv, input int len);
    rd_cnt = 0; wb_cnt = 0; mg_cnt = 0; undo_cnt = 0; sq_cnt = 0;
    done_cnt = 0; bad_order = 0; both_cnt = 0;
    last_succ = 1'b0; last_fail = 1'b0;
    @(posedge clk); #1;
    pred_value = pv; correct_value = cv; slice_len = 6'(len); resolve_valid = 1'b1;
    @(posedge clk); #1;
    resolve_valid = 1'b0;
    for (int k = 0; k < 200 && done_cnt == 0; k++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R10 reset done", 32'(done), 0);
    chk("R9 reset squash", 32'(squash_req), 0);
    chk("R2 reset read", 32'(slice_rd_en), 0);
  endtask

  task automatic t_discard();
    clear_slice();
    set_ent(0, 2'd0, 3'd3, 3'd1, 3'd2, 16'h0, 16'h0, 1'b0);
    run(16'h0042, 16'h0042, 1);
    chk("R1 discard success", 32'(last_succ), 1);
    chk("R1 discard reads", 32'(rd_cnt), 0);
    chk("R1 discard writeback", 32'(wb_cnt), 0);
    chk("R10 discard single done", 32'(done_cnt), 1);
  endtask

  task automatic t_full_replay();
    clear_slice();
    set_ent(0, 2'd0, 3'd3, 3'd1, 3'd2, 16'h0,   16'h0,   1'b0);
    set_ent(1, 2'd1, 3'd4, 3'd3, 3'd0, 16'h4,   16'h214, 1'b0);
    set_ent(2, 2'd2, 3'd0, 3'd5, 3'd4, 16'h0,   16'h500, 1'b0);
    set_ent(3, 2'd3, 3'd0, 3'd1, 3'd2, 16'h0,   16'h0,   1'b0);
    set_ent(4, 2'd0, 3'd4, 3'd4, 3'd1, 16'h0,   16'h0,   1'b0);
    set_ent(5, 2'd2, 3'd0, 3'd5, 3'd4, 16'h0,   16'h500, 1'b0);
    set_ent(6, 2'd2, 3'd0, 3'd6, 3'd3, 16'h2,   16'h602, 1'b0);
    hit_addr = 16'hFFFF;
    run(16'h0020, 16'h0010, 7);
    chk("R2 read count", 32'(rd_cnt), 7);
    chk("R2 read order", 32'(bad_order), 0);
    chk("R10 success", 32'(last_succ), 1);
    chk("R10 one done", 32'(done_cnt), 1);
    chk("R10 verdict exclusive", 32'(both_cnt), 0);
    chk("R8 wb count", 32'(wb_cnt), 3);
    chk("R8 wb0 idx", 32'(wb_i[0]), 1);
    chk("R3 wb0 seed", 32'(wb_d[0]), 32'h0010);
    chk("R8 wb1 idx", 32'(wb_i[1]), 3);
    chk("R3 add result", 32'(wb_d[1]), 32'h0210);
    chk("R8 wb2 idx", 32'(wb_i[2]), 4);
    chk("R3 load then add", 32'(wb_d[2]), 32'h585E);
    chk("R8 merge count", 32'(mg_cnt), 2);
    chk("R8 merge0 addr", 32'(mg_a[0]), 32'h0500);
    chk("R7 merge0 last data", 32'(mg_d[0]), 32'h585E);
    chk("R8 merge1 addr", 32'(mg_a[1]), 32'h0602);
    chk("R8 merge1 data", 32'(mg_d[1]), 32'h0210);
    chk("R7 undo count", 32'(undo_cnt), 2);
    chk("R7 undo0", 32'(un_a[0]), 32'h0500);
    chk("R7 undo1", 32'(un_a[1]), 32'h0602);
    chk("R9 no squash on success", 32'(sq_cnt), 0);
  endtask

  task automatic t_branch();
    clear_slice();
    set_ent(0, 2'd0, 3'd3, 3'd1, 3'd2, 16'h0, 16'h0, 1'b0);
    set_ent(1, 2'd3, 3'd0, 3'd1, 3'd1, 16'h0, 16'h0, 1'b0);
    set_ent(2, 2'd0, 3'd5, 3'd1, 3'd1, 16'h0, 16'h0, 1'b0);
    run(16'h0099, 16'h0030, 3);
    chk("R4 branch flip fails", 32'(last_fail), 1);
    chk("R12 stop after branch", 32'(rd_cnt), 2);
    chk("R9 squash once", 32'(sq_cnt), 1);
    chk("R9 no writeback", 32'(wb_cnt), 0);
    chk("R9 no merge", 32'(mg_cnt), 0);
  endtask

  task automatic t_load_moved();
    clear_slice();
    set_ent(0, 2'd1, 3'd2, 3'd1, 3'd0, 16'h0, 16'h0040, 1'b0);
    set_ent(1, 2'd0, 3'd3, 3'd2, 3'd2, 16'h0, 16'h0,    1'b0);
    run(16'h0040, 16'h0030, 2);
    chk("R5 moved load fails", 32'(last_fail), 1);
    chk("R12 stop after load", 32'(rd_cnt), 1);
  endtask

  task automatic t_store_moved();
    clear_slice();
    set_ent(0, 2'd2, 3'd0, 3'd1, 3'd2, 16'h0, 16'h0040, 1'b0);
    hit_addr = 16'h0999;
    run(16'h0040, 16'h0030, 1);
    chk("R6 moved store no hit ok", 32'(last_succ), 1);
    chk("R6 merge addr", 32'(mg_a[0]), 32'h0030);
    chk("R6 merge data", 32'(mg_d[0]), 32'h0200);
    chk("R8 only seed written", 32'(wb_cnt), 1);
    hit_addr = 16'h0030;
    run(16'h0040, 16'h0030, 1);
    chk("R6 moved store hit fails", 32'(last_fail), 1);
    chk("R9 no merge after fail", 32'(mg_cnt), 0);
    hit_addr = 16'hFFFF;
  endtask

  task automatic t_overflow();
    clear_slice();
    for (int i = 0; i < 5; i++)
      set_ent(i, 2'd2, 3'd0, 3'd2, 3'd3, DW'(i), DW'(16'h0200 + i), 1'b0);
    run(16'h0001, 16'h0002, 5);
    chk("R11 overflow fails", 32'(last_fail), 1);
    chk("R11 reads until overflow", 32'(rd_cnt), 5);
    chk("R7 undo for accepted", 32'(undo_cnt), 4);
  endtask

  task automatic t_empty();
    clear_slice();
    run(16'h0001, 16'h0077, 0);
    chk("R2 empty no reads", 32'(rd_cnt), 0);
    chk("R10 empty success", 32'(last_succ), 1);
    chk("R8 empty wb seed idx", 32'(wb_i[0]), 1);
    chk("R3 empty wb seed value", 32'(wb_d[0]), 32'h0077);
    chk("R8 empty no merge", 32'(mg_cnt), 0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_slice();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_discard();
    t_full_replay();
    t_branch();
    t_load_moved();
    t_store_moved();
    t_overflow();
    t_empty();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule